// File: doc/BRIEF.md
# EDO DRAM Device Responder

This block is a synthesizable, small-capacity stand-in for an asynchronous extended-data-out DRAM. A fast system clock samples the four active-low strobes (row strobe, column strobe, write strobe, output strobe). Every cycle the block compares each sample with the one before it to find strobe edges, and it reacts only to those edges. It takes row and column addresses from one multiplexed address bus and keeps written data in an internal array. It returns read data with extended-data-out hold behaviour. It also runs its own refresh row counter, which moves forward on each column-before-row refresh.

Each access is sorted into one of five kinds: read, early write, read-modify-write, counter refresh, or row-only refresh. The kind is held on a small output code. Every refresh produces a one-clock pulse that carries the row it refreshed. A protocol error pulse reports a row strobe that stayed active, or stayed in precharge, for fewer clocks than a set minimum. The block is meant as a self-checking target for a DRAM controller under test.

All outputs are registered. A strobe edge seen at clock edge k shows on the outputs right after edge k.

Top module: `edo_responder`

## Requirements
- R1: While reset is asserted, and on leaving it, the data drive enable is 0, the kind code is 0 (idle), the refresh pulse and the error pulse are 0, and the refresh counter restarts at row 0.
- R2: A row-strobe fall with the column strobe high latches the row from the address bus. A later column-strobe fall with the write strobe high latches the column, drives the stored word, and sets the kind code to 1 (read).
- R3: If the write strobe is low at the column-strobe fall, the word on the data input is stored at the addressed location, the drive enable stays 0, and the kind code becomes 2 (early write).
- R4: If the write strobe is high at the column-strobe fall and falls later while both address strobes are still low, the old word is driven first. On the write-strobe fall the input word is stored, the drive enable drops, and the kind code becomes 3 (read-modify-write).
- R5: While the row strobe stays low, read data remains driven and unchanged after the column strobe rises. Each new column-strobe fall latches a new column in the same row.
- R6: The drive enable goes to 0 when the output strobe is high, when the row strobe rises with the column strobe high, or when the column strobe rises with the row strobe high. A row-strobe rise with the column strobe still low keeps the data driven.
- R7: A row-strobe fall while the column strobe was already low is a counter refresh. The refresh pulse fires with the counter value as its row, the counter then steps by one and wraps after its last row, the address bus is ignored, and the kind code becomes 4.
- R8: A row strobe that falls and rises again with no column-strobe fall in between refreshes the latched row. The refresh pulse carries that row, and the kind code becomes 5.
- R9: A hidden refresh keeps the column strobe low after a read while the row strobe toggles. The read word stays driven, and each new row-strobe fall performs a counter refresh.
- R10: The error pulse fires for one clock when the row strobe rises after fewer than MIN_RAS low samples, or falls after fewer than MIN_PRE high samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row address strobe, active low |
| casN | input | 1 | Column address strobe, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data |
| dOe | output | 1 | Read data drive enable (0 means high impedance) |
| cycKind | output | 3 | Kind of the last classified access |
| refStb | output | 1 | One-clock pulse per refresh |
| refAddr | output | ROW_W | Row refreshed by the latest refresh |
| protErr | output | 1 | One-clock strobe-timing error pulse |

## Verification
The hidden refresh is the hardest state to reach from the ports. It needs a read whose column strobe is held low through a row-strobe rise, then a fresh row-strobe fall, and each of those phases must last long enough to meet both timing minimums. Otherwise an error pulse would mix with the check. The stimulus table builds this step by step: a read, an extra hold sample, a row-strobe rise with the column strobe low, two precharge samples, and then the counter refresh. It checks that the same word stays driven the whole way through. Counter wrap gets its own directed loop of nine refreshes. Reset is applied in the middle of an active read.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_READ   = 3'd1,
    K_EWRITE = 3'd2,
    K_RMW    = 3'd3,
    K_CBR    = 3'd4,
    K_RASREF = 3'd5
  } kind_e;

  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic wrEn;
    logic rdLoad;
    logic outClr;
    logic cbrRef;
    logic rasRef;
  } strb_t;

endpackage

// File: rtl/edo_ctrl.sv
`timescale 1ns/1ps
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int MIN_RAS = 3,
  parameter int MIN_PRE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       oeN,
  output strb_t      strb,
  output logic       oeQ,
  output logic [2:0] cycKind,
  output logic       protErr
);

  localparam int MAXM  = (MIN_RAS > MIN_PRE) ? MIN_RAS : MIN_PRE;
  localparam int CNT_W = $clog2(MAXM + 1);

  logic rasQ, casQ, weQ;
  logic rowOpen, casSeen, rmwArm;
  logic [CNT_W-1:0] phaseCnt;
  kind_e kindQ;

  logic rasFall, rasRise, casFall, casRise, weFall, oeRise;
  logic cbr, rowStart, colHit, rmwHit, rasRef;

  // edges relative to the previous sample
  assign rasFall = rasQ & ~rasN;
  assign rasRise = ~rasQ & rasN;
  assign casFall = casQ & ~casN;
  assign casRise = ~casQ & casN;
  assign weFall  = weQ & ~weN;
  assign oeRise  = ~oeQ & oeN;

  assign cbr      = rasFall & ~casQ;
  assign rowStart = rasFall & casQ;
  assign colHit   = casFall & ~rasN & rowOpen;
  assign rmwHit   = weFall & ~rasN & ~casN & rmwArm & ~casFall;
  assign rasRef   = rasRise & rowOpen & ~casSeen;

  always_comb begin
    strb.latchRow = rowStart;
    strb.latchCol = colHit;
    strb.wrEn     = (colHit & ~weN) | rmwHit;
    strb.rdLoad   = colHit & weN;
    strb.outClr   = weFall | oeRise | (rasRise & casN) | (casRise & rasN) |
                    (casFall & ~rasN);
    strb.cbrRef   = cbr;
    strb.rasRef   = rasRef;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ     <= 1'b1;
      casQ     <= 1'b1;
      weQ      <= 1'b1;
      oeQ      <= 1'b1;
      rowOpen  <= 1'b0;
      casSeen  <= 1'b0;
      rmwArm   <= 1'b0;
      phaseCnt <= CNT_W'(MAXM);
      kindQ    <= K_IDLE;
      protErr  <= 1'b0;
    end else begin
      rasQ <= rasN;
      casQ <= casN;
      weQ  <= weN;
      oeQ  <= oeN;

      if (rowStart)                  rowOpen <= 1'b1;
      else if (rasRise || cbr)       rowOpen <= 1'b0;

      if (rowStart)                  casSeen <= 1'b0;
      else if (colHit)               casSeen <= 1'b1;

      if (colHit)                    rmwArm <= weN;
      else if (rmwHit || rasRise || casRise) rmwArm <= 1'b0;

      if (rasFall || rasRise)        phaseCnt <= CNT_W'(1);
      else if (phaseCnt < CNT_W'(MAXM)) phaseCnt <= phaseCnt + 1'b1;

      protErr <= (rasRise & (phaseCnt < CNT_W'(MIN_RAS))) |
                 (rasFall & (phaseCnt < CNT_W'(MIN_PRE)));

      if (cbr)                       kindQ <= K_CBR;
      else if (rasRef)               kindQ <= K_RASREF;
      else if (rmwHit)               kindQ <= K_RMW;
      else if (colHit)               kindQ <= weN ? K_READ : K_EWRITE;
    end
  end

  assign cycKind = kindQ;

endmodule

// File: rtl/edo_data.sv
`timescale 1ns/1ps
module edo_data
  import edo_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic              oeQ,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic              refStb,
  output logic [ROW_W-1:0]  refAddr
);

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0]  rowReg, refCnt;
  logic [COL_W-1:0]  colReg, colSel;
  logic [IDX_W-1:0]  idx;
  logic              valid;

  assign colSel = strb.latchCol ? addr[COL_W-1:0] : colReg;
  assign idx    = {rowReg, colSel};

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[idx] <= dIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg  <= '0;
      colReg  <= '0;
      dOut    <= '0;
      valid   <= 1'b0;
      refCnt  <= '0;
      refStb  <= 1'b0;
      refAddr <= '0;
    end else begin
      if (strb.latchRow) rowReg <= addr[ROW_W-1:0];
      if (strb.latchCol) colReg <= addr[COL_W-1:0];
      if (strb.rdLoad)   dOut   <= mem[idx];

      if (strb.rdLoad)      valid <= 1'b1;
      else if (strb.outClr) valid <= 1'b0;

      refStb <= strb.cbrRef | strb.rasRef;
      if (strb.cbrRef) begin
        refAddr <= refCnt;
        refCnt  <= refCnt + 1'b1;
      end else if (strb.rasRef) begin
        refAddr <= rowReg;
      end
    end
  end

  assign dOe = valid & ~oeQ;

endmodule

// File: rtl/edo_responder.sv
`timescale 1ns/1ps
module edo_responder
  import edo_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int MIN_RAS = 3,
  parameter int MIN_PRE = 2,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic [2:0]        cycKind,
  output logic              refStb,
  output logic [ROW_W-1:0]  refAddr,
  output logic              protErr
);

  strb_t strb;
  logic  oeQ;

  edo_ctrl #(.MIN_RAS(MIN_RAS), .MIN_PRE(MIN_PRE)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .strb(strb), .oeQ(oeQ), .cycKind(cycKind), .protErr(protErr)
  );

  edo_data #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .oeQ(oeQ), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOe(dOe), .refStb(refStb), .refAddr(refAddr)
  );

endmodule

// File: rtl/edo_responder_chk.sv
`timescale 1ns/1ps
module edo_responder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic              oeN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOe,
  input logic              refStb,
  input logic              protErr
);

  // R3: write strobe low at a column fall under an active row keeps the pins off
  p_ewrite_hiz_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && $past(casN) && !casN && !weN) |=> !dOe);

  // R4: a write-strobe fall turns the output off
  p_wfall_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(weN) && !weN) |=> !dOe);

  // R5: data held and stable after the column strobe rises under an active row
  p_edo_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && !$past(casN) && casN && !oeN && weN && dOe) |=> (dOe && $stable(dOut)));

  // R6: output strobe high means no drive
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> !dOe);

  // R7: row fall with column already low yields a refresh pulse
  p_cbr_ref_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rasN) && !rasN && !$past(casN)) |=> refStb);

  // R10: a single-sample active row phase is flagged
  p_short_ras_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rasN, 2) && !$past(rasN) && rasN) |=> protErr);

endmodule

bind edo_responder edo_responder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
  .dOut(dOut), .dOe(dOe), .refStb(refStb), .protErr(protErr)
);

// File: tb/edo_responder_tb.sv
`timescale 1ns/1ps
module edo_responder_tb;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0] req;
    logic       r, c, w, o;
    logic [2:0] a;
    logic [7:0] d;
    logic       eOe;
    logic [7:0] eDat;
    logic [2:0] eKind;
    logic       eRef;
    logic [2:0] eRefA;
    logic       eErr;
  } vec_t;

  // ctl holds one hex digit per strobe: row, column, write, output
  function automatic vec_t V(input int q, input int ctl, input int a, input int d,
                             input int eOe, input int eDat, input int eKind,
                             input int eRef, input int eRefA, input int eErr);
    vec_t v;
    v.req = 4'(q);
    v.r = ctl[12]; v.c = ctl[8]; v.w = ctl[4]; v.o = ctl[0];
    v.a = 3'(a); v.d = 8'(d);
    v.eOe = eOe[0]; v.eDat = 8'(eDat); v.eKind = 3'(eKind);
    v.eRef = eRef[0]; v.eRefA = 3'(eRefA); v.eErr = eErr[0];
    return v;
  endfunction

  localparam int NV = 57;
  localparam vec_t VEC [NV] = '{
    V(1,'h1111,0,0,0,0,0,0,0,0),        // R1 idle
    V(2,'h0111,2,0,0,0,0,0,0,0),        // R2 row 2
    V(3,'h0101,5,'hA5,0,0,0,0,0,0),     // R3 write strobe low first
    V(3,'h0001,5,'hA5,0,0,2,0,0,0),     // R3 early write col 5
    V(3,'h0101,1,'h3C,0,0,2,0,0,0),
    V(3,'h0001,1,'h3C,0,0,2,0,0,0),     // R3 early write col 1
    V(3,'h0111,1,0,0,0,2,0,0,0),
    V(8,'h1111,0,0,0,0,2,0,0,0),        // R8 no refresh: column was used
    V(3,'h1111,0,0,0,0,2,0,0,0),
    V(2,'h0110,2,0,0,0,2,0,0,0),
    V(2,'h0010,5,0,1,'hA5,1,0,0,0),     // R2 read
    V(5,'h0110,5,0,1,'hA5,1,0,0,0),     // R5 hold after column rise
    V(5,'h0010,1,0,1,'h3C,1,0,0,0),     // R5 new column same row
    V(5,'h0110,1,0,1,'h3C,1,0,0,0),
    V(6,'h0111,1,0,0,0,1,0,0,0),        // R6 output strobe high
    V(6,'h1110,0,0,0,0,1,0,0,0),        // R6 row rise column high
    V(6,'h1111,0,0,0,0,1,0,0,0),
    V(4,'h0110,2,0,0,0,1,0,0,0),
    V(4,'h0010,5,0,1,'hA5,1,0,0,0),     // R4 old data first
    V(4,'h0000,5,'h5A,0,0,3,0,0,0),     // R4 write strobe fall
    V(4,'h0111,0,0,0,0,3,0,0,0),
    V(4,'h1111,0,0,0,0,3,0,0,0),
    V(4,'h1111,0,0,0,0,3,0,0,0),
    V(4,'h0110,2,0,0,0,3,0,0,0),
    V(4,'h0010,5,0,1,'h5A,1,0,0,0),     // R4 new word stored
    V(5,'h0010,5,0,1,'h5A,1,0,0,0),
    V(6,'h1010,5,0,1,'h5A,1,0,0,0),     // R6 row rises first: stays driven
    V(9,'h1010,5,0,1,'h5A,1,0,0,0),
    V(9,'h0010,7,0,1,'h5A,4,1,0,0),     // R9 hidden refresh row 0
    V(9,'h0010,7,0,1,'h5A,4,0,0,0),
    V(9,'h0010,7,0,1,'h5A,4,0,0,0),
    V(9,'h1010,7,0,1,'h5A,4,0,0,0),
    V(6,'h1110,0,0,0,0,4,0,0,0),        // R6 column rise row high
    V(6,'h1111,0,0,0,0,4,0,0,0),
    V(7,'h1011,0,0,0,0,4,0,0,0),
    V(7,'h0011,6,0,0,0,4,1,1,0),        // R7 refresh row 1, addr 6 ignored
    V(7,'h0011,6,0,0,0,4,0,0,0),
    V(7,'h0011,6,0,0,0,4,0,0,0),
    V(7,'h1111,0,0,0,0,4,0,0,0),
    V(7,'h1111,0,0,0,0,4,0,0,0),
    V(8,'h0111,4,0,0,0,4,0,0,0),
    V(8,'h0111,4,0,0,0,4,0,0,0),
    V(8,'h0111,4,0,0,0,4,0,0,0),
    V(8,'h1111,0,0,0,0,5,1,4,0),        // R8 row-only refresh row 4
    V(8,'h1111,0,0,0,0,5,0,0,0),
    V(10,'h0111,3,0,0,0,5,0,0,0),
    V(10,'h1111,0,0,0,0,5,1,3,1),       // R10 short active phase
    V(10,'h1111,0,0,0,0,5,0,0,0),
    V(10,'h0111,1,0,0,0,5,0,0,0),
    V(10,'h0111,1,0,0,0,5,0,0,0),
    V(10,'h0111,1,0,0,0,5,0,0,0),
    V(10,'h1111,0,0,0,0,5,1,1,0),
    V(10,'h0111,2,0,0,0,5,0,0,1),       // R10 short precharge
    V(10,'h0111,2,0,0,0,5,0,0,0),
    V(10,'h0111,2,0,0,0,5,0,0,0),
    V(10,'h1111,0,0,0,0,5,1,2,0),
    V(10,'h1111,0,0,0,0,5,0,0,0)
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] dIn = '0;
  logic [7:0] dOut;
  logic dOe, refStb, protErr;
  logic [2:0] cycKind, refAddr;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  edo_responder u_dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe), .cycKind(cycKind),
    .refStb(refStb), .refAddr(refAddr), .protErr(protErr)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic w, input logic o,
                       input logic [2:0] a, input logic [7:0] d);
    rasN = r; casN = c; weN = w; oeN = o; addr = a; dIn = d;
    @(negedge clk);
  endtask

  task automatic chkVec(input vec_t v);
    chk(dOe === v.eOe, int'(v.req), "dOe", int'(dOe), int'(v.eOe));
    if (v.eOe) chk(dOut === v.eDat, int'(v.req), "dOut", int'(dOut), int'(v.eDat));
    chk(cycKind === v.eKind, int'(v.req), "kind", int'(cycKind), int'(v.eKind));
    chk(refStb === v.eRef, int'(v.req), "refStb", int'(refStb), int'(v.eRef));
    if (v.eRef) chk(refAddr === v.eRefA, int'(v.req), "refAddr", int'(refAddr), int'(v.eRefA));
    chk(protErr === v.eErr, int'(v.req), "protErr", int'(protErr), int'(v.eErr));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 state after reset
    chk(dOe === 1'b0, 1, "dOe", int'(dOe), 0);
    chk(cycKind === 3'd0, 1, "kind", int'(cycKind), 0);
    chk(refStb === 1'b0 && protErr === 1'b0, 1, "pulses", int'({refStb, protErr}), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].r, VEC[i].c, VEC[i].w, VEC[i].o, VEC[i].a, VEC[i].d);
      chkVec(VEC[i]);
    end

    // R7 counter steps and wraps; two counter refreshes already done
    for (int k = 0; k < 9; k++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 8'h00);
      chk(refStb === 1'b1, 7, "refStb", int'(refStb), 1);
      chk(refAddr === 3'((2 + k) % 8), 7, "refAddr wrap", int'(refAddr), (2 + k) % 8);
      chk(cycKind === 3'd4, 7, "kind", int'(cycKind), 4);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
      drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
      chk(protErr === 1'b0, 10, "protErr", int'(protErr), 0);
      drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
    end

    // R1 reset during an active read
    drive(1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 8'h00);
    chk(dOe === 1'b1 && dOut === 8'h5A, 2, "read before reset", int'(dOut), 'h5A);
    rstN = 1'b0;
    @(negedge clk);
    chk(dOe === 1'b0, 1, "dOe in reset", int'(dOe), 0);
    chk(cycKind === 3'd0, 1, "kind in reset", int'(cycKind), 0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
    rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 8'h00);
    chk(refStb === 1'b1 && refAddr === 3'd0, 1, "counter restart", int'(refAddr), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule